// File: doc/BRIEF.md
# Outstanding Transaction ID Tracker

This block watches a split request/response interface and records which transaction identifiers are currently in flight. Each identifier owns one slot with an active flag. An accepted request sets its slot's flag on the next clock edge, and the response carrying the same identifier clears it. The slot also keeps the request's type and priority for as long as it is in flight. After completion it keeps the type of the response that closed it.

The block has two roles. As an allocator, it offers the requester the lowest-numbered free identifier and says whether any identifier is free at all. As a monitor, it flags two protocol faults. The first is a request that reuses an identifier still in flight. It gives a one-cycle pulse and a sticky error. The second is a response for an identifier that is not in flight. It gives a separate sticky error. When a request and a response name the same identifier in one cycle, the clear takes priority.

Top module: `txn_id_tracker`

## Requirements
- R1: A synchronous active-high reset clears every active flag, every stored request type, priority and response type, the reuse pulse, and both sticky error outputs.
- R2: A request whose identifier names an inactive slot makes that slot active on the next clock edge. From that edge, its 3-bit type and 2-bit priority read back on `rd_req_type` and `rd_req_prio` when `rd_id` selects the slot.
- R3: A response whose identifier names an active slot makes that slot inactive on the next clock edge. From then on, the stored request type and priority of that slot read back as zero.
- R4: When a request and a response name the same slot in the same cycle, the slot is inactive after the edge.
- R5: A request naming an already active slot drives `reuse_pulse` high for exactly the cycle after that request and sets `reuse_err`, which then stays high until reset. The slot stays active and its stored type and priority are unchanged.
- R6: A response naming an inactive slot sets `orphan_err`, which stays high until reset, and the slot stays inactive.
- R7: A slot named by neither a request nor a response in a cycle keeps its active value. A request and a response on two different slots in one cycle both take effect.
- R8: `free_id` is the lowest-numbered inactive slot and `free_avail` is 1 while any slot is inactive. When all four slots are active, `free_avail` is 0 and `free_id` is 0. Both follow the active flags without a register.
- R9: The 2-bit response type that clears a slot reads back on `rd_rsp_type` for that slot until the slot is next made active, which zeroes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_id | input | 2 | Request identifier |
| req_type | input | 3 | Request type |
| req_prio | input | 2 | Request priority |
| rsp_valid | input | 1 | Response present this cycle |
| rsp_id | input | 2 | Response identifier |
| rsp_type | input | 2 | Response type |
| rd_id | input | 2 | Slot selected for read-back |
| active_o | output | 4 | Active flag per slot, bit n for identifier n |
| free_avail | output | 1 | At least one identifier is free |
| free_id | output | 2 | Lowest free identifier |
| reuse_pulse | output | 1 | One-cycle mark of a request on a busy identifier |
| reuse_err | output | 1 | Sticky busy-identifier error |
| orphan_err | output | 1 | Sticky response-without-request error |
| rd_req_type | output | 3 | Stored request type of the selected slot |
| rd_req_prio | output | 2 | Stored request priority of the selected slot |
| rd_rsp_type | output | 2 | Closing response type of the selected slot |

## Verification
The properties assume that the interface inputs are driven to known values in every cycle after reset. They relate each request or response only to the flags on the next edge. They do not assume legal traffic: reuse and orphan cases are checked as events the block must report. The stimulus changes inputs only between clock edges and holds them steady across each edge. It keeps legal traffic in the table phase, and then provokes each fault on purpose in directed steps.

// File: rtl/txn_trk_pkg.sv
package txn_trk_pkg;

    // Default widths of the tracked interface
    localparam int unsigned DEF_ID_W       = 2;
    localparam int unsigned DEF_REQ_TYPE_W = 3;
    localparam int unsigned DEF_PRIO_W     = 2;
    localparam int unsigned DEF_RSP_TYPE_W = 2;

    // Fault reporting state held by the top module
    typedef struct packed {
        logic reuse_pulse;
        logic reuse_err;
        logic orphan_err;
    } trk_err_t;

endpackage

// File: rtl/trk_slot.sv
module trk_slot #(
    parameter int unsigned REQ_TYPE_W = 3,
    parameter int unsigned PRIO_W     = 2,
    parameter int unsigned RSP_TYPE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_i,
    input  logic                  clr_i,
    input  logic [REQ_TYPE_W-1:0] req_type_i,
    input  logic [PRIO_W-1:0]     req_prio_i,
    input  logic [RSP_TYPE_W-1:0] rsp_type_i,
    output logic                  active_o,
    output logic [REQ_TYPE_W-1:0] req_type_o,
    output logic [PRIO_W-1:0]     req_prio_o,
    output logic [RSP_TYPE_W-1:0] rsp_type_o
);

    typedef struct packed {
        logic                  active;
        logic [REQ_TYPE_W-1:0] rtype;
        logic [PRIO_W-1:0]     prio;
        logic [RSP_TYPE_W-1:0] done_type;
    } slot_state_t;

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            // completion has priority over a same-cycle request
            st_d.active    = 1'b0;
            st_d.rtype     = '0;
            st_d.prio      = '0;
            st_d.done_type = rsp_type_i;
        end else if (set_i && !st_q.active) begin
            st_d.active    = 1'b1;
            st_d.rtype     = req_type_i;
            st_d.prio      = req_prio_i;
            st_d.done_type = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o   = st_q.active;
    assign req_type_o = st_q.rtype;
    assign req_prio_o = st_q.prio;
    assign rsp_type_o = st_q.done_type;

endmodule

// File: rtl/trk_free_pick.sv
module trk_free_pick #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned ID_W  = 2
) (
    input  logic [SLOTS-1:0] active_i,
    output logic             avail_o,
    output logic [ID_W-1:0]  id_o
);

    always_comb begin
        id_o = '0;
        // walk downward so the lowest free index is the last one written
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!active_i[i]) begin
                id_o = ID_W'(i);
            end
        end
        avail_o = ~&active_i;
    end

endmodule

// File: rtl/txn_id_tracker.sv
module txn_id_tracker
    import txn_trk_pkg::*;
#(
    parameter int unsigned ID_W       = DEF_ID_W,
    parameter int unsigned REQ_TYPE_W = DEF_REQ_TYPE_W,
    parameter int unsigned PRIO_W     = DEF_PRIO_W,
    parameter int unsigned RSP_TYPE_W = DEF_RSP_TYPE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [ID_W-1:0]            req_id,
    input  logic [REQ_TYPE_W-1:0]      req_type,
    input  logic [PRIO_W-1:0]          req_prio,
    input  logic                       rsp_valid,
    input  logic [ID_W-1:0]            rsp_id,
    input  logic [RSP_TYPE_W-1:0]      rsp_type,
    input  logic [ID_W-1:0]            rd_id,
    output logic [(1<<ID_W)-1:0]       active_o,
    output logic                       free_avail,
    output logic [ID_W-1:0]            free_id,
    output logic                       reuse_pulse,
    output logic                       reuse_err,
    output logic                       orphan_err,
    output logic [REQ_TYPE_W-1:0]      rd_req_type,
    output logic [PRIO_W-1:0]          rd_req_prio,
    output logic [RSP_TYPE_W-1:0]      rd_rsp_type
);

    localparam int unsigned SLOTS = 1 << ID_W;

    logic [SLOTS-1:0]      set_vec;
    logic [SLOTS-1:0]      clr_vec;
    logic [SLOTS-1:0]      act_vec;
    logic [REQ_TYPE_W-1:0] type_arr [SLOTS];
    logic [PRIO_W-1:0]     prio_arr [SLOTS];
    logic [RSP_TYPE_W-1:0] done_arr [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign set_vec[g] = req_valid && (req_id == ID_W'(g));
        assign clr_vec[g] = rsp_valid && (rsp_id == ID_W'(g));

        trk_slot #(
            .REQ_TYPE_W (REQ_TYPE_W),
            .PRIO_W     (PRIO_W),
            .RSP_TYPE_W (RSP_TYPE_W)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .set_i      (set_vec[g]),
            .clr_i      (clr_vec[g]),
            .req_type_i (req_type),
            .req_prio_i (req_prio),
            .rsp_type_i (rsp_type),
            .active_o   (act_vec[g]),
            .req_type_o (type_arr[g]),
            .req_prio_o (prio_arr[g]),
            .rsp_type_o (done_arr[g])
        );
    end

    trk_free_pick #(
        .SLOTS (SLOTS),
        .ID_W  (ID_W)
    ) u_pick (
        .active_i (act_vec),
        .avail_o  (free_avail),
        .id_o     (free_id)
    );

    trk_err_t err_d, err_q;

    always_comb begin
        err_d             = err_q;
        err_d.reuse_pulse = req_valid && act_vec[req_id];
        if (req_valid && act_vec[req_id]) begin
            err_d.reuse_err = 1'b1;
        end
        if (rsp_valid && !act_vec[rsp_id]) begin
            err_d.orphan_err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign active_o    = act_vec;
    assign reuse_pulse = err_q.reuse_pulse;
    assign reuse_err   = err_q.reuse_err;
    assign orphan_err  = err_q.orphan_err;
    assign rd_req_type = type_arr[rd_id];
    assign rd_req_prio = prio_arr[rd_id];
    assign rd_rsp_type = done_arr[rd_id];

endmodule

// File: rtl/txn_id_tracker_sva.sv
module txn_id_tracker_sva #(
    parameter int unsigned ID_W = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [ID_W-1:0]      req_id,
    input logic                 rsp_valid,
    input logic [ID_W-1:0]      rsp_id,
    input logic [(1<<ID_W)-1:0] active_o,
    input logic                 free_avail,
    input logic [ID_W-1:0]      free_id,
    input logic                 reuse_pulse,
    input logic                 reuse_err,
    input logic                 orphan_err
);

    // R1: state is cleared on the edge after reset is sampled
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (active_o == '0 && !reuse_err && !orphan_err && !reuse_pulse));

    // R2: a request on an inactive slot with no competing response sets it
    a_r2_set: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !active_o[req_id] && !(rsp_valid && rsp_id == req_id))
        |=> active_o[$past(req_id)]);

    // R3: a response leaves its slot inactive
    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !active_o[$past(rsp_id)]);

    // R4: same-slot request and response resolve to inactive
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_valid && req_id == rsp_id) |=> !active_o[$past(req_id)]);

    // R5: reuse of a busy identifier is marked next cycle
    a_r5_reuse_pulse: assert property (@(posedge clk) disable iff (rst)
        (req_valid && active_o[req_id]) |=> (reuse_pulse && reuse_err));

    // R5: reuse error is sticky
    a_r5_reuse_sticky: assert property (@(posedge clk) disable iff (rst)
        reuse_err |=> reuse_err);

    // R6: response to an inactive slot raises the orphan error
    a_r6_orphan: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !active_o[rsp_id]) |=> orphan_err);

    // R6: orphan error is sticky
    a_r6_orphan_sticky: assert property (@(posedge clk) disable iff (rst)
        orphan_err |=> orphan_err);

    // R7: with no traffic the flags hold
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !rsp_valid) |=> $stable(active_o));

    // R8: the offered identifier is really free; no offer means all busy
    a_r8_free_ok: assert property (@(posedge clk) disable iff (rst)
        free_avail |-> !active_o[free_id]);

    a_r8_none_free: assert property (@(posedge clk) disable iff (rst)
        !free_avail |-> (&active_o));

endmodule

bind txn_id_tracker txn_id_tracker_sva #(.ID_W(ID_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_id      (req_id),
    .rsp_valid   (rsp_valid),
    .rsp_id      (rsp_id),
    .active_o    (active_o),
    .free_avail  (free_avail),
    .free_id     (free_id),
    .reuse_pulse (reuse_pulse),
    .reuse_err   (reuse_err),
    .orphan_err  (orphan_err)
);

// File: tb/tb_txn_id_tracker.sv
`timescale 1ns/1ps
module tb_txn_id_tracker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_id = '0;
    logic [2:0] req_type = '0;
    logic [1:0] req_prio = '0;
    logic       rsp_valid = 1'b0;
    logic [1:0] rsp_id = '0;
    logic [1:0] rsp_type = '0;
    logic [1:0] rd_id = '0;
    logic [3:0] active_o;
    logic       free_avail;
    logic [1:0] free_id;
    logic       reuse_pulse, reuse_err, orphan_err;
    logic [2:0] rd_req_type;
    logic [1:0] rd_req_prio;
    logic [1:0] rd_rsp_type;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    txn_id_tracker dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_id(req_id), .req_type(req_type), .req_prio(req_prio),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_type(rsp_type),
        .rd_id(rd_id), .active_o(active_o), .free_avail(free_avail), .free_id(free_id),
        .reuse_pulse(reuse_pulse), .reuse_err(reuse_err), .orphan_err(orphan_err),
        .rd_req_type(rd_req_type), .rd_req_prio(rd_req_prio), .rd_rsp_type(rd_rsp_type)
    );

    typedef struct packed {
        logic       rq;
        logic [1:0] rq_id;
        logic [2:0] rq_ty;
        logic [1:0] rq_pr;
        logic       rs;
        logic [1:0] rs_id;
        logic [3:0] act;
        logic       avail;
        logic [1:0] fid;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 3'd5, 2'd2, 1'b0, 2'd0, 4'b0001, 1'b1, 2'd1},
        '{1'b1, 2'd1, 3'd3, 2'd1, 1'b0, 2'd0, 4'b0011, 1'b1, 2'd2},
        '{1'b0, 2'd0, 3'd0, 2'd0, 1'b1, 2'd0, 4'b0010, 1'b1, 2'd0},
        '{1'b1, 2'd2, 3'd7, 2'd3, 1'b1, 2'd1, 4'b0100, 1'b1, 2'd0},
        '{1'b0, 2'd0, 3'd0, 2'd0, 1'b0, 2'd0, 4'b0100, 1'b1, 2'd0},
        '{1'b1, 2'd3, 3'd2, 2'd1, 1'b0, 2'd0, 4'b1100, 1'b1, 2'd0},
        '{1'b1, 2'd0, 3'd6, 2'd2, 1'b0, 2'd0, 4'b1101, 1'b1, 2'd1},
        '{1'b1, 2'd1, 3'd4, 2'd3, 1'b0, 2'd0, 4'b1111, 1'b0, 2'd0},
        '{1'b0, 2'd0, 3'd0, 2'd0, 1'b1, 2'd3, 4'b0111, 1'b1, 2'd3},
        '{1'b1, 2'd3, 3'd0, 2'd0, 1'b1, 2'd2, 4'b1011, 1'b1, 2'd2}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rsp_valid = 1'b0;
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; req_id = '0; req_type = '0; req_prio = '0;
        rsp_valid = 1'b0; rsp_id = '0; rsp_type = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: state after reset
        chk("R1", "active after reset", int'(active_o), 0);
        chk("R1", "errors after reset", int'({reuse_pulse, reuse_err, orphan_err}), 0);
        rst = 1'b0;

        // Table phase: legal traffic, R2 R3 R7 R8
        for (int k = 0; k < NV; k++) begin
            req_valid = VECS[k].rq;  req_id = VECS[k].rq_id;
            req_type  = VECS[k].rq_ty; req_prio = VECS[k].rq_pr;
            rsp_valid = VECS[k].rs;  rsp_id = VECS[k].rs_id; rsp_type = '0;
            step();
            chk("R2/R3/R7", $sformatf("active row %0d", k), int'(active_o), int'(VECS[k].act));
            chk("R8", $sformatf("free_avail row %0d", k), int'(free_avail), int'(VECS[k].avail));
            chk("R8", $sformatf("free_id row %0d", k), int'(free_id), int'(VECS[k].fid));
            chk("R5/R6", $sformatf("no fault row %0d", k),
                int'({reuse_pulse, reuse_err, orphan_err}), 0);
        end
        idle_inputs();

        // R2: stored request fields read back (slots 0 and 1 active)
        rd_id = 2'd0; #1;
        chk("R2", "slot0 type", int'(rd_req_type), 6);
        chk("R2", "slot0 prio", int'(rd_req_prio), 2);
        rd_id = 2'd1; #1;
        chk("R2", "slot1 type", int'(rd_req_type), 4);
        chk("R2", "slot1 prio", int'(rd_req_prio), 3);

        // R3 R9: complete slot 1 with response type 3
        rsp_valid = 1'b1; rsp_id = 2'd1; rsp_type = 2'd3;
        step();
        rd_id = 2'd1; #1;
        chk("R3", "active after rsp1", int'(active_o), 4'b1001);
        chk("R3", "slot1 type cleared", int'(rd_req_type), 0);
        chk("R3", "slot1 prio cleared", int'(rd_req_prio), 0);
        chk("R9", "slot1 closing rsp type", int'(rd_rsp_type), 3);
        chk("R6", "no orphan on legal rsp", int'(orphan_err), 0);

        // R5: request reuses busy slot 0
        req_valid = 1'b1; req_id = 2'd0; req_type = 3'd1; req_prio = 2'd1;
        step();
        rd_id = 2'd0; #1;
        chk("R5", "reuse pulse", int'(reuse_pulse), 1);
        chk("R5", "reuse err", int'(reuse_err), 1);
        chk("R5", "slot0 still active", int'(active_o), 4'b1001);
        chk("R5", "slot0 type kept", int'(rd_req_type), 6);
        chk("R5", "slot0 prio kept", int'(rd_req_prio), 2);
        step();
        chk("R5", "pulse one cycle", int'(reuse_pulse), 0);
        chk("R5", "reuse err sticky", int'(reuse_err), 1);

        // R4: same-slot request and response on active slot 3
        req_valid = 1'b1; req_id = 2'd3; req_type = 3'd5; req_prio = 2'd1;
        rsp_valid = 1'b1; rsp_id = 2'd3; rsp_type = 2'd2;
        step();
        rd_id = 2'd3; #1;
        chk("R4", "clear wins", int'(active_o), 4'b0001);
        chk("R9", "slot3 closing rsp type", int'(rd_rsp_type), 2);

        // R6: response to inactive slot 2
        rsp_valid = 1'b1; rsp_id = 2'd2; rsp_type = 2'd1;
        step();
        chk("R6", "orphan err", int'(orphan_err), 1);
        chk("R6", "slot2 stays inactive", int'(active_o), 4'b0001);
        step();
        chk("R6", "orphan sticky", int'(orphan_err), 1);

        // R1: mid-run reset
        rst = 1'b1;
        step();
        rst = 1'b0;
        rd_id = 2'd0; #1;
        chk("R1", "active cleared", int'(active_o), 0);
        chk("R1", "errors cleared", int'({reuse_pulse, reuse_err, orphan_err}), 0);
        chk("R1", "slot0 meta cleared", int'({rd_req_type, rd_req_prio}), 0);
        rd_id = 2'd3; #1;
        chk("R1", "slot3 rsp type cleared", int'(rd_rsp_type), 0);
        chk("R8", "free after reset", int'({free_avail, free_id}), 3'b100);

        finish_run();
    end

endmodule